// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and the two integer execution pipes. Each cycle it looks at two consecutive decoded instructions, the older one (slot 0) and the younger one (slot 1). It decides whether both may issue together, with slot 0 going to the U pipe and slot 1 going to the V pipe. If they may not, only slot 0 issues, to U. It returns a single pair-issue flag. It also returns a reason code that names the first restriction that blocked pairing.

Each slot arrives as a small descriptor. The descriptor carries a single-cycle ("simple") flag, a floating-point opcode class, an exchange-top-of-stack flag, register write and read masks, and immediate and displacement flags. Slot 1 also carries a prefix flag. Slot 0's read mask and prefix cannot change the decision, so they are not ports.

A parameter selects a registered result (the default) or a purely combinational one.

Top module: `pair_issue_check`

## Requirements
- R1: When `i1_valid` is low, the result is single issue (`pair_issue` 0) with reason code 1.
- R2: When an integer member of the pair has its simple flag low, pairing is refused with reason code 2. Floating-point members are exempt from this rule.
- R3: When any bit set in `i0_dst` is also set in `i1_src` (read after write), pairing is refused with reason code 5.
- R4: When any bit set in `i0_dst` is also set in `i1_dst` (write after write), pairing is refused with reason code 6.
- R5: When either member has both its immediate flag and its displacement flag high, pairing is refused with reason code 4. An immediate alone does not block pairing.
- R6: When the prefix flag of slot 1 is high, pairing is refused with reason code 3, because a prefixed instruction may only run in the U pipe.
- R7: A member counts as floating-point when its class field is non-zero or its exchange flag is set. If either member is floating-point, the pair issues only under two conditions. First, slot 0 has class 1 to 8 (1 load, 2 add, 3 multiply, 4 divide, 5 compare, 6 test, 7 absolute value, 8 change sign) with its exchange flag clear. Second, slot 1 has its exchange flag set with class 0. Any other case gives reason code 7.
- R8: When several rules fail, the reason code reports the first one in this order: 2, then 3, 4, 5, 6, 7. Reason code 1 overrides all of them.
- R9: When every rule passes, `pair_issue` is 1 and the reason code is 0. `pair_issue` is high exactly when the reason code is 0.
- R10: With `OUT_REG`=1, both outputs reflect the inputs sampled at the previous rising clock edge. An active-low asynchronous reset forces `pair_issue` to 0 and the reason code to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| i1_valid | input | 1 | Slot 1 holds a real instruction |
| i0_simple | input | 1 | Slot 0 is single-cycle hardwired |
| i0_fpc | input | FPC_W | Slot 0 floating-point class, 0 for integer |
| i0_fxch | input | 1 | Slot 0 is the stack exchange instruction |
| i0_dst | input | REG_W | Slot 0 register write mask |
| i0_imm | input | 1 | Slot 0 has an immediate operand |
| i0_disp | input | 1 | Slot 0 has a displacement |
| i1_simple | input | 1 | Slot 1 is single-cycle hardwired |
| i1_fpc | input | FPC_W | Slot 1 floating-point class, 0 for integer |
| i1_fxch | input | 1 | Slot 1 is the stack exchange instruction |
| i1_dst | input | REG_W | Slot 1 register write mask |
| i1_src | input | REG_W | Slot 1 register read mask |
| i1_imm | input | 1 | Slot 1 has an immediate operand |
| i1_disp | input | 1 | Slot 1 has a displacement |
| i1_prefix | input | 1 | Slot 1 carries a prefix |
| pair_issue | output | 1 | Both slots issue together |
| reason | output | 4 | Code of the first failing rule, 0 when paired |

## Verification
With the default registered output, both `pair_issue` and `reason` are due one rising edge after the slot descriptors are presented. The bench drives each vector on a falling edge and compares on the following falling edge. A latency probe looks at the outputs just after new inputs are driven, and requires that they still show the earlier result. Reset takes effect without a clock edge, so the mid-run reset check samples one time unit after `rst_n` falls.

// File: rtl/pair_issue_pkg.sv
`timescale 1ns/1ps
package pair_issue_pkg;

    typedef enum logic [3:0] {
        RSN_PAIRED     = 4'd0,
        RSN_NO_SECOND  = 4'd1,
        RSN_NOT_SIMPLE = 4'd2,
        RSN_PREFIX_V   = 4'd3,
        RSN_IMM_DISP   = 4'd4,
        RSN_RAW        = 4'd5,
        RSN_WAW        = 4'd6,
        RSN_FP_RULE    = 4'd7
    } reason_e;

    // Floating-point classes that may lead an exchange pair form a
    // contiguous range; class 0 marks an integer instruction.
    localparam int FPC_INT   = 0;
    localparam int FPC_FIRST = 1;   // load
    localparam int FPC_LAST  = 8;   // change sign

endpackage

// File: rtl/pair_slot_class.sv
`timescale 1ns/1ps
module pair_slot_class #(
    parameter int FPC_W = 4
) (
    input  logic             simple,
    input  logic [FPC_W-1:0] fpc,
    input  logic             fxch,
    input  logic             imm,
    input  logic             disp,
    output logic             is_fp,
    output logic             int_complex,
    output logic             imm_disp
);
    // A slot is floating-point if it has a class or is the exchange.
    assign is_fp       = fxch | (fpc != '0);
    // The simple rule only constrains integer members.
    assign int_complex = ~is_fp & ~simple;
    assign imm_disp    = imm & disp;
endmodule

// File: rtl/pair_hazard.sv
`timescale 1ns/1ps
module pair_hazard #(
    parameter int REG_W = 8
) (
    input  logic [REG_W-1:0] i0_dst,
    input  logic [REG_W-1:0] i1_src,
    input  logic [REG_W-1:0] i1_dst,
    output logic             raw,
    output logic             waw
);
    logic [REG_W-1:0] raw_bit;
    logic [REG_W-1:0] waw_bit;

    for (genvar g = 0; g < REG_W; g++) begin : g_reg
        assign raw_bit[g] = i0_dst[g] & i1_src[g];
        assign waw_bit[g] = i0_dst[g] & i1_dst[g];
    end

    assign raw = |raw_bit;
    assign waw = |waw_bit;
endmodule

// File: rtl/pair_fp_rule.sv
`timescale 1ns/1ps
module pair_fp_rule
    import pair_issue_pkg::*;
#(
    parameter int FPC_W = 4
) (
    input  logic             any_fp,
    input  logic [FPC_W-1:0] i0_fpc,
    input  logic             i0_fxch,
    input  logic [FPC_W-1:0] i1_fpc,
    input  logic             i1_fxch,
    output logic             fp_fail
);
    logic lead_ok;
    logic exch_ok;

    assign lead_ok = ~i0_fxch
                   & (i0_fpc >= FPC_W'(FPC_FIRST))
                   & (i0_fpc <= FPC_W'(FPC_LAST));
    assign exch_ok = i1_fxch & (i1_fpc == FPC_W'(FPC_INT));
    assign fp_fail = any_fp & ~(lead_ok & exch_ok);
endmodule

// File: rtl/pair_rule_prio.sv
`timescale 1ns/1ps
module pair_rule_prio
    import pair_issue_pkg::*;
(
    input  logic    i1_valid,
    input  logic    not_simple,
    input  logic    v_prefix,
    input  logic    imm_disp,
    input  logic    raw,
    input  logic    waw,
    input  logic    fp_fail,
    output logic    pair,
    output reason_e rsn
);
    always_comb begin
        if (!i1_valid)       rsn = RSN_NO_SECOND;
        else if (not_simple) rsn = RSN_NOT_SIMPLE;
        else if (v_prefix)   rsn = RSN_PREFIX_V;
        else if (imm_disp)   rsn = RSN_IMM_DISP;
        else if (raw)        rsn = RSN_RAW;
        else if (waw)        rsn = RSN_WAW;
        else if (fp_fail)    rsn = RSN_FP_RULE;
        else                 rsn = RSN_PAIRED;
    end

    assign pair = (rsn == RSN_PAIRED);
endmodule

// File: rtl/pair_issue_check.sv
`timescale 1ns/1ps
module pair_issue_check
    import pair_issue_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int FPC_W   = 4,
    parameter int OUT_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i1_valid,
    input  logic             i0_simple,
    input  logic [FPC_W-1:0] i0_fpc,
    input  logic             i0_fxch,
    input  logic [REG_W-1:0] i0_dst,
    input  logic             i0_imm,
    input  logic             i0_disp,
    input  logic             i1_simple,
    input  logic [FPC_W-1:0] i1_fpc,
    input  logic             i1_fxch,
    input  logic [REG_W-1:0] i1_dst,
    input  logic [REG_W-1:0] i1_src,
    input  logic             i1_imm,
    input  logic             i1_disp,
    input  logic             i1_prefix,
    output logic             pair_issue,
    output logic [3:0]       reason
);
    localparam int SLOTS = 2;

    logic [SLOTS-1:0] simple_v;
    logic [SLOTS-1:0] fxch_v;
    logic [SLOTS-1:0] imm_v;
    logic [SLOTS-1:0] disp_v;
    logic [FPC_W-1:0] fpc_v [SLOTS];

    logic [SLOTS-1:0] is_fp;
    logic [SLOTS-1:0] cplx;
    logic [SLOTS-1:0] immdisp;

    logic    raw;
    logic    waw;
    logic    fp_fail;
    logic    pair_c;
    reason_e rsn_c;

    assign simple_v = {i1_simple, i0_simple};
    assign fxch_v   = {i1_fxch, i0_fxch};
    assign imm_v    = {i1_imm, i0_imm};
    assign disp_v   = {i1_disp, i0_disp};
    assign fpc_v[0] = i0_fpc;
    assign fpc_v[1] = i1_fpc;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        pair_slot_class #(.FPC_W(FPC_W)) u_cls (
            .simple      (simple_v[s]),
            .fpc         (fpc_v[s]),
            .fxch        (fxch_v[s]),
            .imm         (imm_v[s]),
            .disp        (disp_v[s]),
            .is_fp       (is_fp[s]),
            .int_complex (cplx[s]),
            .imm_disp    (immdisp[s])
        );
    end

    pair_hazard #(.REG_W(REG_W)) u_haz (
        .i0_dst (i0_dst),
        .i1_src (i1_src),
        .i1_dst (i1_dst),
        .raw    (raw),
        .waw    (waw)
    );

    pair_fp_rule #(.FPC_W(FPC_W)) u_fp (
        .any_fp  (|is_fp),
        .i0_fpc  (i0_fpc),
        .i0_fxch (i0_fxch),
        .i1_fpc  (i1_fpc),
        .i1_fxch (i1_fxch),
        .fp_fail (fp_fail)
    );

    pair_rule_prio u_prio (
        .i1_valid   (i1_valid),
        .not_simple (|cplx),
        .v_prefix   (i1_prefix),
        .imm_disp   (|immdisp),
        .raw        (raw),
        .waw        (waw),
        .fp_fail    (fp_fail),
        .pair       (pair_c),
        .rsn        (rsn_c)
    );

    if (OUT_REG != 0) begin : g_reg
        logic    pair_q;
        reason_e rsn_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pair_q <= 1'b0;
                rsn_q  <= RSN_NO_SECOND;
            end else begin
                pair_q <= pair_c;
                rsn_q  <= rsn_c;
            end
        end

        assign pair_issue = pair_q;
        assign reason     = rsn_q;
    end else begin : g_comb
        assign pair_issue = pair_c;
        assign reason     = rsn_c;
    end
endmodule

// File: rtl/pair_issue_check_sva.sv
`timescale 1ns/1ps
module pair_issue_check_sva #(
    parameter int REG_W   = 8,
    parameter int FPC_W   = 4,
    parameter int OUT_REG = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i1_valid,
    input logic             i0_simple,
    input logic [FPC_W-1:0] i0_fpc,
    input logic             i0_fxch,
    input logic [REG_W-1:0] i0_dst,
    input logic             i0_imm,
    input logic             i0_disp,
    input logic             i1_simple,
    input logic [FPC_W-1:0] i1_fpc,
    input logic             i1_fxch,
    input logic [REG_W-1:0] i1_dst,
    input logic [REG_W-1:0] i1_src,
    input logic             i1_imm,
    input logic             i1_disp,
    input logic             i1_prefix,
    input logic             pair_issue,
    input logic [3:0]       reason
);
    if (OUT_REG != 0) begin : g_chk
        p_no_second_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(i1_valid) |-> !pair_issue && reason == 4'd1);

        p_complex_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(i1_valid &&
                ((i0_fpc == '0 && !i0_fxch && !i0_simple) ||
                 (i1_fpc == '0 && !i1_fxch && !i1_simple))) |-> !pair_issue);

        p_raw_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past((i0_dst & i1_src) != '0) |-> !pair_issue);

        p_waw_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past((i0_dst & i1_dst) != '0) |-> !pair_issue);

        p_imm_disp_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past((i0_imm && i0_disp) || (i1_imm && i1_disp))
            |-> !pair_issue);

        p_prefix_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(i1_prefix) |-> !pair_issue);

        p_flag_matches_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pair_issue == (reason == 4'd0));
    end
endmodule

bind pair_issue_check pair_issue_check_sva #(
    .REG_W(REG_W), .FPC_W(FPC_W), .OUT_REG(OUT_REG)
) u_sva (.*);

// File: tb/pair_issue_check_test.sv
`timescale 1ns/1ps
module pair_issue_check_test;

    typedef struct packed {
        logic       s;
        logic [3:0] fc;
        logic       x;
        logic [7:0] d;
        logic [7:0] r;
        logic       im;
        logic       di;
        logic       pf;
    } desc_t;

    typedef struct packed {
        logic       bv;
        desc_t      a;
        desc_t      b;
        logic       ep;
        logic [3:0] er;
        logic [3:0] rq;
    } vec_t;

    localparam desc_t D_ADD_R0 = '{1'b1, 4'd0, 1'b0, 8'h01, 8'h02, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_ADD_R2 = '{1'b1, 4'd0, 1'b0, 8'h04, 8'h08, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_RD_R0  = '{1'b1, 4'd0, 1'b0, 8'h10, 8'h01, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_WR_R0  = '{1'b1, 4'd0, 1'b0, 8'h01, 8'h20, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_RW_R0  = '{1'b1, 4'd0, 1'b0, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_CPX    = '{1'b0, 4'd0, 1'b0, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_PFX    = '{1'b1, 4'd0, 1'b0, 8'h20, 8'h00, 1'b0, 1'b0, 1'b1};
    localparam desc_t D_PFXID  = '{1'b1, 4'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1};
    localparam desc_t D_IMDI   = '{1'b1, 4'd0, 1'b0, 8'h08, 8'h00, 1'b1, 1'b1, 1'b0};
    localparam desc_t D_IMM    = '{1'b1, 4'd0, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0};
    localparam desc_t D_FLD    = '{1'b1, 4'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_FLD_R0 = '{1'b1, 4'd1, 1'b0, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_FADD   = '{1'b1, 4'd2, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_FCHS   = '{1'b1, 4'd8, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_FOTH   = '{1'b1, 4'd9, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0};
    localparam desc_t D_FXCH   = '{1'b1, 4'd0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0};

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, D_ADD_R0, D_ADD_R2, 1'b1, 4'd0, 4'd9},  // R9 clean pair
        '{1'b0, D_ADD_R0, D_ADD_R2, 1'b0, 4'd1, 4'd1},  // R1 slot 1 empty
        '{1'b1, D_CPX,    D_ADD_R2, 1'b0, 4'd2, 4'd2},  // R2 slot 0 complex
        '{1'b1, D_ADD_R2, D_CPX,    1'b0, 4'd2, 4'd2},  // R2 slot 1 complex
        '{1'b1, D_ADD_R2, D_PFX,    1'b0, 4'd3, 4'd6},  // R6 prefix in V
        '{1'b1, D_PFX,    D_ADD_R2, 1'b1, 4'd0, 4'd9},  // R9 pair
        '{1'b1, D_IMDI,   D_ADD_R0, 1'b0, 4'd4, 4'd5},  // R5 slot 0
        '{1'b1, D_ADD_R0, D_IMDI,   1'b0, 4'd4, 4'd5},  // R5 slot 1
        '{1'b1, D_IMM,    D_ADD_R0, 1'b1, 4'd0, 4'd5},  // R5 imm alone ok
        '{1'b1, D_ADD_R0, D_RD_R0,  1'b0, 4'd5, 4'd3},  // R3 raw
        '{1'b1, D_ADD_R0, D_WR_R0,  1'b0, 4'd6, 4'd4},  // R4 waw
        '{1'b1, D_FLD,    D_FXCH,   1'b1, 4'd0, 4'd7},  // R7 load+exch
        '{1'b1, D_FCHS,   D_FXCH,   1'b1, 4'd0, 4'd7},  // R7 chs+exch
        '{1'b1, D_FOTH,   D_FXCH,   1'b0, 4'd7, 4'd7},  // R7 class 9
        '{1'b1, D_FLD,    D_FADD,   1'b0, 4'd7, 4'd7},  // R7 no exch
        '{1'b1, D_ADD_R0, D_FXCH,   1'b0, 4'd7, 4'd7},  // R7 int lead
        '{1'b1, D_FXCH,   D_FXCH,   1'b0, 4'd7, 4'd7},  // R7 exch lead
        '{1'b1, D_FLD,    D_ADD_R2, 1'b0, 4'd7, 4'd7},  // R7 fp then int
        '{1'b1, D_CPX,    D_PFX,    1'b0, 4'd2, 4'd8},  // R8 2 over 3
        '{1'b1, D_ADD_R2, D_PFXID,  1'b0, 4'd3, 4'd8},  // R8 3 over 4
        '{1'b1, D_IMDI,   D_ADD_R2, 1'b0, 4'd4, 4'd8},  // R8 4 over 5
        '{1'b1, D_ADD_R0, D_RW_R0,  1'b0, 4'd5, 4'd8},  // R8 5 over 6
        '{1'b1, D_ADD_R0, D_FLD_R0, 1'b0, 4'd5, 4'd8},  // R8 5 over 7
        '{1'b1, D_FLD,    D_CPX,    1'b0, 4'd2, 4'd8}   // R8 2 over 7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i1_valid = 1'b0;
    logic       i0_simple = 1'b0, i1_simple = 1'b0;
    logic [3:0] i0_fpc = '0, i1_fpc = '0;
    logic       i0_fxch = 1'b0, i1_fxch = 1'b0;
    logic [7:0] i0_dst = '0, i1_dst = '0, i1_src = '0;
    logic       i0_imm = 1'b0, i0_disp = 1'b0;
    logic       i1_imm = 1'b0, i1_disp = 1'b0, i1_prefix = 1'b0;
    logic       pair_issue;
    logic [3:0] reason;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pair_issue_check uut (
        .clk(clk), .rst_n(rst_n), .i1_valid(i1_valid),
        .i0_simple(i0_simple), .i0_fpc(i0_fpc), .i0_fxch(i0_fxch),
        .i0_dst(i0_dst), .i0_imm(i0_imm), .i0_disp(i0_disp),
        .i1_simple(i1_simple), .i1_fpc(i1_fpc), .i1_fxch(i1_fxch),
        .i1_dst(i1_dst), .i1_src(i1_src), .i1_imm(i1_imm),
        .i1_disp(i1_disp), .i1_prefix(i1_prefix),
        .pair_issue(pair_issue), .reason(reason)
    );

    task automatic drive(input logic bv, input desc_t a, input desc_t b);
        i1_valid  = bv;
        i0_simple = a.s;  i0_fpc = a.fc; i0_fxch = a.x;
        i0_dst    = a.d;  i0_imm = a.im; i0_disp = a.di;
        i1_simple = b.s;  i1_fpc = b.fc; i1_fxch = b.x;
        i1_dst    = b.d;  i1_src = b.r;  i1_imm  = b.im;
        i1_disp   = b.di; i1_prefix = b.pf;
    endtask

    task automatic check(input string req, input logic ep, input logic [3:0] er);
        n_chk++;
        if (pair_issue !== ep) begin
            n_bad++;
            $display("FAIL %s pair_issue got %0b expected %0b", req, pair_issue, ep);
        end
        n_chk++;
        if (reason !== er) begin
            n_bad++;
            $display("FAIL %s reason got %0d expected %0d", req, reason, er);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        drive(1'b1, D_ADD_R0, D_ADD_R2);
        repeat (3) @(negedge clk);
        check("R10 reset", 1'b0, 4'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].bv, VEC[i].a, VEC[i].b);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].ep, VEC[i].er);
        end

        // R10 latency: pair result, then new inputs must not show until an edge
        drive(1'b1, D_FLD, D_FXCH);
        @(negedge clk);
        check("R10 load", 1'b1, 4'd0);
        drive(1'b0, D_FLD, D_FXCH);
        #1;
        check("R10 hold", 1'b1, 4'd0);
        @(negedge clk);
        check("R10 update", 1'b0, 4'd1);

        // R10 asynchronous reset mid-run
        drive(1'b1, D_ADD_R0, D_ADD_R2);
        @(negedge clk);
        check("R10 pre-reset", 1'b1, 4'd0);
        rst_n = 1'b0;
        #1;
        check("R10 async reset", 1'b0, 4'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", 1'b1, 4'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule